// File: doc/BRIEF.md
# Emulated Clock-Chip Interrupt Generator

This block produces the three interrupt kinds of a classic real-time-clock chip (once-per-second update, time-of-day alarm and a programmable periodic tick) from one one-shot compare channel that watches a free-running main counter. The comparator is never put into a hardware periodic mode. After each compare event the block re-arms it in logic: it adds one event interval to the previous compare value, and it detects and recovers deadlines that have already passed.

The time of day is kept elsewhere and arrives on input ports. Software-side controls arrive as single-cycle pulses: set or clear any of the three source enables, load an alarm time, and load a periodic rate as a power-of-two exponent. The interval for the 64 Hz base event rate arrives on `baseTicks`, counted in main-counter ticks. Faster periodic rates are derived from it by right shifts. At each compare event that produces at least one flag, the block emits a one-cycle strobe and a 16-bit flag word.

Top module: `rtc_irq_emu`

## Requirements
- R1: After reset the comparator is disarmed, `cmpValue` is 0, all three sources are disabled, the stored rate exponent is 6 (64 Hz), the last-seen seconds value and the alarm time are 0, and `irqStrobe` and `irqWord` are 0.
- R2: A pulse on `enSet` while no source is enabled arms the comparator, one cycle later, at `counter` plus the interval of the event rate that the new enables select. `enSet`/`enClr` bit 0 is update, bit 1 is alarm and bit 2 is periodic; set wins over clear in the same cycle.
- R3: The event interval is `baseTicks` while the periodic source is off or the rate exponent k is at most 6. With the periodic source on and k above 6 it is `baseTicks >> (k-6)`. A rate exponent k means 2^k Hz, with k from 1 to 13.
- R4: An event occurs when the comparator is armed and the signed difference `counter - cmpValue` is zero or positive. The new compare value is the old compare value plus the interval, not `counter` plus the interval, and counter wrap is handled.
- R5: If, after that step, `counter - cmpValue` (signed) is still above zero, the lost count L = (difference / interval) + 2 is computed. The compare value then advances by L intervals, and while the periodic source is on, the periodic count grows by L.
- R6: With the update source on, an event raises the update flag when `todSec` differs from the last-seen seconds value, and stores `todSec` as the new last-seen value.
- R7: With the periodic source on, every event increments the periodic count. When the count reaches 64/2^k (or 1 for k above 6), the periodic flag is raised and the count returns to 0.
- R8: With the alarm source on, an event raises the alarm flag only when hours, minutes and seconds all equal the stored alarm time.
- R9: `irqWord` is nonzero only during an `irqStrobe` cycle, and `irqStrobe` pulses only for events that raise a flag. The word carries update at bit 4, alarm at bit 5, periodic at bit 6, the pending bit at bit 7 and the value 1 in bits 15:8.
- R10: A `rateWr` pulse, or setting the periodic enable, clears the periodic count. This clear takes priority over any count update in the same cycle.
- R11: An event with all sources disabled disarms the comparator, raises no flag and leaves `cmpValue` unchanged. No further event occurs until a source is enabled again.
- R12: `irqStrobe` rises 3 cycles after the cycle in which an on-time event is seen, and CNT_W+4 cycles after it for a late event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| counter | input | CNT_W | Free-running main counter value |
| baseTicks | input | CNT_W | Counter ticks per 64 Hz event |
| todHour | input | TOD_W | Current hours |
| todMin | input | TOD_W | Current minutes |
| todSec | input | TOD_W | Current seconds |
| enSet | input | 3 | Pulse: enable sources (bit0 update, bit1 alarm, bit2 periodic) |
| enClr | input | 3 | Pulse: disable sources, same bit order |
| alarmWr | input | 1 | Pulse: load the alarm time |
| alarmHour | input | TOD_W | Alarm hours |
| alarmMin | input | TOD_W | Alarm minutes |
| alarmSec | input | TOD_W | Alarm seconds |
| rateWr | input | 1 | Pulse: load the periodic rate exponent |
| rateLog2 | input | RATE_W | Periodic rate exponent k (2^k Hz) |
| cmpArmed | output | 1 | Compare channel enabled |
| cmpValue | output | CNT_W | Current compare value |
| irqStrobe | output | 1 | One-cycle pulse with a flag word |
| irqWord | output | 16 | Interrupt flag word |

## Verification
The bench sweeps every rate exponent from 1 to 13. At each rate it runs enough events to see the periodic flag twice, which catches an off-by-one threshold (a flag one event early or late) and a wrong shift for the fast rates (a wrong interval in `cmpValue`). The events run the compare value past the 16-bit wrap, so an unsigned comparison would stall or fire at once. Late events are placed exactly on the new deadline, which must not count as late, and at several distances beyond it. A design that rescheduled from the counter or dropped the +2 would leave the compare value wrong, and one that did not add lost events to the periodic count would shift every later periodic flag. Further cases cover a rate rewrite in mid-count, which must restart the divider; partial alarm matches, which must stay silent; a repeated seconds value, which must not raise an update; and an event with every source off, which must disarm the comparator and stay quiet.

// File: rtl/rtc_irq_emu_pkg.sv
package rtc_irq_emu_pkg;

  localparam int WORD_W    = 16;
  localparam int BASE_LOG2 = 6;   // 64 Hz base event rate
  localparam int SRC_N     = 3;

  // source enable bit positions
  localparam int EN_UPD = 0;
  localparam int EN_ALM = 1;
  localparam int EN_PER = 2;

  // flag word bit positions
  localparam int BIT_UPD  = 4;
  localparam int BIT_ALM  = 5;
  localparam int BIT_PER  = 6;
  localparam int BIT_PEND = 7;
  localparam int CNT_LSB  = 8;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_CHECK,
    ST_DIV,
    ST_FIX,
    ST_EVAL
  } ctrlState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic armInit;
    logic rearm;
    logic snap;
    logic divStep;
    logic fixApply;
    logic evalGo;
    logic disarm;
  } dpCmd_t;

endpackage

// File: rtl/rtc_irq_emu_div.sv
module rtc_irq_emu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W:0]   remAcc;
  logic [W-1:0] quoAcc;
  logic [W:0]   shifted;
  logic [W:0]   trial;

  assign shifted = {remAcc[W-1:0], quoAcc[W-1]};
  assign trial   = shifted - {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remAcc <= '0;
      quoAcc <= '0;
    end else if (start) begin
      remAcc <= '0;
      quoAcc <= dividend;
    end else if (step) begin
      if (trial[W]) begin
        remAcc <= shifted;
        quoAcc <= {quoAcc[W-2:0], 1'b0};
      end else begin
        remAcc <= trial;
        quoAcc <= {quoAcc[W-2:0], 1'b1};
      end
    end
  end

  assign quo = quoAcc;
  assign rem = remAcc[W-1:0];

endmodule

// File: rtl/rtc_irq_emu_ctrl.sv
module rtc_irq_emu_ctrl
  import rtc_irq_emu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   hit,
  input  logic   late,
  input  logic   anyEn,
  input  logic   armReq,
  output dpCmd_t cmd
);
  localparam int STEP_W = $clog2(CNT_W + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CNT_W - 1);

  ctrlState_t state, nextState;
  logic [STEP_W-1:0] stepCnt;

  always_comb begin
    cmd       = '0;
    nextState = state;
    if (armReq) begin
      cmd.armInit = 1'b1;
      nextState   = ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (hit) begin
            if (anyEn) begin
              cmd.rearm = 1'b1;
              nextState = ST_CHECK;
            end else begin
              cmd.disarm = 1'b1;
            end
          end
        end
        ST_CHECK: begin
          if (late) begin
            cmd.snap  = 1'b1;
            nextState = ST_DIV;
          end else begin
            nextState = ST_EVAL;
          end
        end
        ST_DIV: begin
          cmd.divStep = 1'b1;
          if (stepCnt == LAST_STEP) nextState = ST_FIX;
        end
        ST_FIX: begin
          cmd.fixApply = 1'b1;
          nextState    = ST_EVAL;
        end
        ST_EVAL: begin
          cmd.evalGo = 1'b1;
          nextState  = ST_WAIT;
        end
        default: nextState = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_WAIT;
      stepCnt <= '0;
    end else begin
      state <= nextState;
      if (cmd.snap)         stepCnt <= '0;
      else if (cmd.divStep) stepCnt <= stepCnt + 1'b1;
    end
  end

  // R12: the divider phase always runs its full length before the fix-up
  a_r12_div_length: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIV && stepCnt == LAST_STEP && !armReq) |=> (cmd.fixApply || armReq));

  // R5: the late path is entered only from the check state
  a_r5_snap_from_check: assert property (@(posedge clk) disable iff (!rstN)
    cmd.snap |-> $past(cmd.rearm));

endmodule

// File: rtl/rtc_irq_emu_dp.sv
module rtc_irq_emu_dp
  import rtc_irq_emu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TOD_W  = 8,
  parameter int RATE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic [CNT_W-1:0]    counter,
  input  logic [CNT_W-1:0]    baseTicks,
  input  logic [TOD_W-1:0]    todHour,
  input  logic [TOD_W-1:0]    todMin,
  input  logic [TOD_W-1:0]    todSec,
  input  logic [SRC_N-1:0]    enSet,
  input  logic [SRC_N-1:0]    enClr,
  input  logic                alarmWr,
  input  logic [TOD_W-1:0]    alarmHour,
  input  logic [TOD_W-1:0]    alarmMin,
  input  logic [TOD_W-1:0]    alarmSec,
  input  logic                rateWr,
  input  logic [RATE_W-1:0]   rateLog2,
  output logic                hit,
  output logic                late,
  output logic                anyEn,
  output logic                armReq,
  output logic                cmpArmed,
  output logic [CNT_W-1:0]    cmpValue,
  output logic                irqStrobe,
  output logic [WORD_W-1:0]   irqWord
);
  localparam logic [RATE_W-1:0] BASE_K  = RATE_W'(BASE_LOG2);
  localparam logic [CNT_W-1:0]  BASE_HZ = CNT_W'(1) << BASE_LOG2;

  logic [SRC_N-1:0]  enFlags, enNext;
  logic [RATE_W-1:0] rateReg, rateNext;
  logic [TOD_W-1:0]  almHour, almMin, almSec, lastSec;
  logic [CNT_W-1:0]  pCnt, cmp, tpeLat, snapCount;
  logic              armed;
  logic              strobeR;
  logic [WORD_W-1:0] wordR;

  logic [CNT_W-1:0]  tpeCur, tpeArm, gap, quo, rem, lostCnt, perThr, pCntInc;
  logic              updHit, almHit, perHit, anyHit, perClr;

  function automatic logic [CNT_W-1:0] tpeFor(input logic perOn,
                                              input logic [RATE_W-1:0] k,
                                              input logic [CNT_W-1:0] base);
    if (perOn && (k > BASE_K)) return base >> (k - BASE_K);
    return base;
  endfunction

  assign enNext   = (enFlags & ~enClr) | enSet;
  assign rateNext = rateWr ? rateLog2 : rateReg;
  assign tpeCur   = tpeFor(enFlags[EN_PER], rateReg, baseTicks);
  assign tpeArm   = tpeFor(enNext[EN_PER], rateNext, baseTicks);

  assign anyEn  = |enFlags;
  assign armReq = (|enSet) && !anyEn;

  // signed window compare handles counter wrap
  assign gap  = counter - cmp;
  assign hit  = armed && !gap[CNT_W-1];
  assign late = !gap[CNT_W-1] && (gap != '0);

  rtc_irq_emu_div #(.W(CNT_W)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .start    (cmd.snap),
    .step     (cmd.divStep),
    .dividend (gap),
    .divisor  (tpeLat),
    .quo      (quo),
    .rem      (rem)
  );

  assign lostCnt = quo + CNT_W'(2);

  // periodic divider threshold: base rate over requested rate
  assign perThr  = (rateReg > BASE_K) ? CNT_W'(1) : (BASE_HZ >> rateReg);
  assign pCntInc = pCnt + CNT_W'(1);
  assign perClr  = rateWr || enSet[EN_PER];

  assign updHit = enFlags[EN_UPD] && (todSec != lastSec);
  assign almHit = enFlags[EN_ALM] && (todHour == almHour) &&
                  (todMin == almMin) && (todSec == almSec);
  assign perHit = enFlags[EN_PER] && (pCntInc >= perThr);
  assign anyHit = updHit || almHit || perHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enFlags   <= '0;
      rateReg   <= BASE_K;
      almHour   <= '0;
      almMin    <= '0;
      almSec    <= '0;
      lastSec   <= '0;
      pCnt      <= '0;
      cmp       <= '0;
      tpeLat    <= '0;
      snapCount <= '0;
      armed     <= 1'b0;
      strobeR   <= 1'b0;
      wordR     <= '0;
    end else begin
      enFlags <= enNext;
      rateReg <= rateNext;
      if (alarmWr) begin
        almHour <= alarmHour;
        almMin  <= alarmMin;
        almSec  <= alarmSec;
      end

      // compare channel
      if (cmd.armInit) begin
        cmp   <= counter + tpeArm;
        armed <= 1'b1;
      end else if (cmd.disarm) begin
        armed <= 1'b0;
      end else if (cmd.rearm) begin
        cmp    <= cmp + tpeCur;
        tpeLat <= tpeCur;
      end else if (cmd.fixApply) begin
        // old + L*interval == snapshot - remainder + 2*interval
        cmp <= snapCount - rem + (tpeLat << 1);
      end
      if (cmd.snap) snapCount <= counter;

      // periodic divider count
      if (perClr) begin
        pCnt <= '0;
      end else if (cmd.fixApply && enFlags[EN_PER]) begin
        pCnt <= pCnt + lostCnt;
      end else if (cmd.evalGo && enFlags[EN_PER]) begin
        pCnt <= perHit ? '0 : pCntInc;
      end

      // flag evaluation
      strobeR <= 1'b0;
      wordR   <= '0;
      if (cmd.evalGo) begin
        if (updHit) lastSec <= todSec;
        if (anyHit) begin
          strobeR                       <= 1'b1;
          wordR[WORD_W-1:CNT_LSB]       <= (WORD_W-CNT_LSB)'(1);
          wordR[BIT_PEND]               <= 1'b1;
          wordR[BIT_PER]                <= perHit;
          wordR[BIT_ALM]                <= almHit;
          wordR[BIT_UPD]                <= updHit;
        end
      end
    end
  end

  assign cmpArmed  = armed;
  assign cmpValue  = cmp;
  assign irqStrobe = strobeR;
  assign irqWord   = wordR;

  logic [CNT_W-1:0] aheadOfSnap;
  assign aheadOfSnap = cmp - snapCount;

  // R5: after recovery the compare value lies in the future of the snapshot
  a_r5_future_after_fix: assert property (@(posedge clk) disable iff (!rstN)
    cmd.fixApply |=> (!aheadOfSnap[CNT_W-1] && aheadOfSnap != '0));

  // R9: word layout during a strobe
  a_r9_word_format: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe |-> (irqWord[BIT_PEND] && irqWord[WORD_W-1:CNT_LSB] == (WORD_W-CNT_LSB)'(1)
                   && irqWord[BIT_PER:BIT_UPD] != '0));

  // R9: the word is quiet outside a strobe
  a_r9_quiet_word: assert property (@(posedge clk) disable iff (!rstN)
    !irqStrobe |-> irqWord == '0);

  // R10: a rate write leaves the periodic count at zero
  a_r10_rate_clears: assert property (@(posedge clk) disable iff (!rstN)
    rateWr |=> pCnt == '0);

  // R11: a quiet event turns the compare channel off
  a_r11_disarm: assert property (@(posedge clk) disable iff (!rstN)
    cmd.disarm |=> (!cmpArmed && $stable(cmpValue)));

  // R2: an initial arm leaves the channel armed
  a_r2_arm: assert property (@(posedge clk) disable iff (!rstN)
    cmd.armInit |=> cmpArmed);

  // R12: strobe only follows the evaluation step
  a_r12_strobe_after_eval: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStrobe) |-> $past(cmd.evalGo));

endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
  import rtc_irq_emu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TOD_W  = 8,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  counter,
  input  logic [CNT_W-1:0]  baseTicks,
  input  logic [TOD_W-1:0]  todHour,
  input  logic [TOD_W-1:0]  todMin,
  input  logic [TOD_W-1:0]  todSec,
  input  logic [2:0]        enSet,
  input  logic [2:0]        enClr,
  input  logic              alarmWr,
  input  logic [TOD_W-1:0]  alarmHour,
  input  logic [TOD_W-1:0]  alarmMin,
  input  logic [TOD_W-1:0]  alarmSec,
  input  logic              rateWr,
  input  logic [RATE_W-1:0] rateLog2,
  output logic              cmpArmed,
  output logic [CNT_W-1:0]  cmpValue,
  output logic              irqStrobe,
  output logic [15:0]       irqWord
);
  dpCmd_t cmd;
  logic   hit, late, anyEn, armReq;

  rtc_irq_emu_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .hit    (hit),
    .late   (late),
    .anyEn  (anyEn),
    .armReq (armReq),
    .cmd    (cmd)
  );

  rtc_irq_emu_dp #(.CNT_W(CNT_W), .TOD_W(TOD_W), .RATE_W(RATE_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .counter   (counter),
    .baseTicks (baseTicks),
    .todHour   (todHour),
    .todMin    (todMin),
    .todSec    (todSec),
    .enSet     (enSet),
    .enClr     (enClr),
    .alarmWr   (alarmWr),
    .alarmHour (alarmHour),
    .alarmMin  (alarmMin),
    .alarmSec  (alarmSec),
    .rateWr    (rateWr),
    .rateLog2  (rateLog2),
    .hit       (hit),
    .late      (late),
    .anyEn     (anyEn),
    .armReq    (armReq),
    .cmpArmed  (cmpArmed),
    .cmpValue  (cmpValue),
    .irqStrobe (irqStrobe),
    .irqWord   (irqWord)
  );

endmodule

// File: tb/tb_rtc_irq_emu.sv
module tb_rtc_irq_emu;
  localparam int CW   = 16;
  localparam int TW   = 8;
  localparam int RW   = 4;
  localparam logic [CW-1:0] BASE = 16'd1000;
  localparam int LAT_ON   = 3;
  localparam int LAT_LATE = CW + 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [CW-1:0] counter;
  logic [TW-1:0] todHour, todMin, todSec;
  logic [2:0]    enSet, enClr;
  logic          alarmWr, rateWr;
  logic [TW-1:0] alarmHour, alarmMin, alarmSec;
  logic [RW-1:0] rateLog2;
  logic          cmpArmed, irqStrobe;
  logic [CW-1:0] cmpValue;
  logic [15:0]   irqWord;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model state
  logic [CW-1:0] mCmp;
  logic          mArmed;
  logic [2:0]    mEn;
  int            mRate, mPcnt;
  logic [TW-1:0] mLast, mAh, mAm, mAs;

  always #4 clk = ~clk;

  rtc_irq_emu #(.CNT_W(CW), .TOD_W(TW), .RATE_W(RW)) dut (
    .clk(clk), .rstN(rstN), .counter(counter), .baseTicks(BASE),
    .todHour(todHour), .todMin(todMin), .todSec(todSec),
    .enSet(enSet), .enClr(enClr), .alarmWr(alarmWr),
    .alarmHour(alarmHour), .alarmMin(alarmMin), .alarmSec(alarmSec),
    .rateWr(rateWr), .rateLog2(rateLog2),
    .cmpArmed(cmpArmed), .cmpValue(cmpValue),
    .irqStrobe(irqStrobe), .irqWord(irqWord)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] tpeOf();
    if (mEn[2] && mRate > 6) return BASE >> (mRate - 6);
    return BASE;
  endfunction

  task automatic doReset();
    rstN = 1'b0; counter = '0; enSet = '0; enClr = '0;
    alarmWr = 1'b0; rateWr = 1'b0; rateLog2 = '0;
    alarmHour = '0; alarmMin = '0; alarmSec = '0;
    todHour = '0; todMin = '0; todSec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mCmp = '0; mArmed = 1'b0; mEn = '0; mRate = 6; mPcnt = 0;
    mLast = '0; mAh = '0; mAm = '0; mAs = '0;
  endtask

  task automatic setRate(input int k);
    @(negedge clk);
    rateLog2 = RW'(k); rateWr = 1'b1;
    @(negedge clk);
    rateWr = 1'b0;
    mRate = k; mPcnt = 0;
  endtask

  task automatic enOn(input logic [2:0] mask);
    bit armReq;
    @(negedge clk);
    enSet = mask;
    armReq = (mask != 0) && (mEn == 0);
    mEn = mEn | mask;
    if (mask[2]) mPcnt = 0;
    if (armReq) begin
      mCmp = counter + tpeOf();
      mArmed = 1'b1;
    end
    @(negedge clk);
    enSet = '0;
    chk(cmpArmed == mArmed, "R2 armed", cmpArmed, mArmed);
    chk(cmpValue == mCmp, "R2/R3 arm value", cmpValue, mCmp);
  endtask

  task automatic enOff(input logic [2:0] mask);
    @(negedge clk);
    enClr = mask;
    @(negedge clk);
    enClr = '0;
    mEn = mEn & ~mask;
  endtask

  // counter placed at old compare value plus skip
  task automatic fire(input int skip);
    logic [CW-1:0] t, d;
    bit late, upd, alm, per, any;
    logic [15:0] expWord;
    int lat, q, thr;
    @(negedge clk);
    counter = mCmp + CW'(skip);
    if (mEn == 0) begin
      mArmed = 1'b0;
      repeat (LAT_ON) @(posedge clk);
      @(negedge clk);
      chk(!irqStrobe, "R11 no strobe", irqStrobe, 0);
      chk(!cmpArmed, "R11 disarmed", cmpArmed, 0);
      chk(cmpValue == mCmp, "R11 value kept", cmpValue, mCmp);
      return;
    end
    t = tpeOf();
    mCmp = mCmp + t;
    d = counter - mCmp;
    late = (d != 0) && !d[CW-1];
    lat = LAT_ON;
    if (late) begin
      q = int'(d / t);
      mCmp = mCmp + CW'((q + 2) * int'(t));
      if (mEn[2]) mPcnt = mPcnt + q + 2;
      lat = LAT_LATE;
    end
    upd = mEn[0] && (todSec != mLast);
    if (upd) mLast = todSec;
    alm = mEn[1] && todHour == mAh && todMin == mAm && todSec == mAs;
    per = 1'b0;
    if (mEn[2]) begin
      mPcnt++;
      thr = (mRate > 6) ? 1 : (64 >> mRate);
      if (mPcnt >= thr) begin per = 1'b1; mPcnt = 0; end
    end
    any = upd || alm || per;
    expWord = any ? {8'd1, 1'b1, per, alm, upd, 4'b0} : 16'd0;
    repeat (lat - 1) @(posedge clk);
    @(negedge clk);
    chk(!irqStrobe, "R12 not early", irqStrobe, 0);
    @(posedge clk);
    @(negedge clk);
    chk(irqStrobe == any, "R12 strobe timing", irqStrobe, any);
    chk(irqWord == expWord, "R9 word (R6/R7/R8 flags)", irqWord, expWord);
    chk(cmpValue == mCmp, late ? "R5 recovered value" : "R4 rescheduled value",
        cmpValue, mCmp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    chk(!cmpArmed, "R1 armed", cmpArmed, 0);
    chk(cmpValue == 0, "R1 value", cmpValue, 0);
    chk(!irqStrobe, "R1 strobe", irqStrobe, 0);
    chk(irqWord == 0, "R1 word", irqWord, 0);

    // R3 / R7 sweep over every rate
    for (int k = 1; k <= 13; k++) begin
      int nev;
      doReset();
      counter = 16'd100;
      setRate(k);
      enOn(3'b100);
      nev = (k <= 6) ? 2 * (64 >> k) + 1 : 4;
      for (int e = 0; e < nev; e++) fire(0);
    end

    // R10 rate rewrite in mid-count
    doReset();
    setRate(2);
    enOn(3'b100);
    for (int e = 0; e < 5; e++) fire(0);
    setRate(2);
    for (int e = 0; e < 17; e++) fire(0);
    enOn(3'b100);   // re-enabling clears the count too (R10)
    for (int e = 0; e < 17; e++) fire(0);

    // R6 update source
    doReset();
    enOn(3'b001);
    fire(0);                       // seconds equal to reset value 0
    todSec = 8'd5; fire(0);
    fire(0);                       // same seconds: quiet
    todSec = 8'd6; fire(0);

    // R8 alarm source
    @(negedge clk);
    alarmHour = 8'd1; alarmMin = 8'd2; alarmSec = 8'd3; alarmWr = 1'b1;
    @(negedge clk);
    alarmWr = 1'b0;
    mAh = 8'd1; mAm = 8'd2; mAs = 8'd3;
    enOn(3'b010);
    todHour = 8'd1; todMin = 8'd2; todSec = 8'd3; fire(0);   // both flags
    fire(0);                                                 // alarm only
    todHour = 8'd9; fire(0);                                 // hour mismatch
    todHour = 8'd1; todMin = 8'd7; fire(0);                  // minute mismatch
    todMin = 8'd2; todSec = 8'd4; fire(0);                   // update only

    // R5 lost-event recovery with periodic count
    todHour = 8'd20;
    enOff(3'b011);
    setRate(1);
    enOn(3'b100);
    fire(int'(BASE));              // exactly on the new deadline: not late
    fire(int'(BASE) + 1);
    fire(int'(BASE) + 3007);
    fire(int'(BASE) * 11);
    for (int e = 0; e < 40; e++) fire(0);
    setRate(9);
    fire(int'(BASE >> 3) + 130);
    fire(0);

    // R11 all sources off at an event
    enOff(3'b111);
    fire(0);
    @(negedge clk);
    counter = counter + 16'd5000;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(!irqStrobe && !cmpArmed, "R11 stays quiet", irqStrobe, 0);
    chk(cmpValue == mCmp, "R11 no new schedule", cmpValue, mCmp);
    enOn(3'b001);                  // R2 re-arm from the counter
    todSec = 8'd33;
    fire(0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule